// File: doc/BRIEF.md
# External Interrupt Request Latch with Edge or Edge-plus-Level Trigger

The block catches interrupt requests arriving on one asynchronous, active-low input pin. It runs the pin through a synchronizer and detects falling edges. It holds each request in a pending latch until the request is acknowledged. The CPU raises the acknowledge with a strobe when it fetches the vector. Software raises the same acknowledge by writing a one to a self-clearing bit in a small status/control register. A mask bit gates only the request that goes to the CPU. The pending flag always shows the true latch state, so that polling code can use it.

A mode bit selects one of two triggers. In edge mode, a falling edge sets the latch and any acknowledge clears it at once. In edge-plus-level mode, a falling edge also sets the latch, but the latch clears only after two conditions are both met: an acknowledge has occurred, and the pin has returned high. The two conditions may come in either order. While the system is in a debug break state, software acknowledges are ignored unless a break-clear-enable input is high. The block also provides the synchronized pin level for polling and a fixed interrupt vector address.

Top module: `xirq_latch`

## Requirements
- R1: A falling edge on `pin_n` sets the pending flag in either mode. The pin passes through two flops before edge detection, so pending shows within three clock edges of the pin change.
- R2: With the mode bit at 0, a vector-fetch strobe or a software acknowledge clears the pending flag in the following cycle.
- R3: With the mode bit at 1, pending clears only once an acknowledge has occurred and the synchronized pin is high. This holds whether the acknowledge comes before or after the pin returns high.
- R4: With the mode bit at 1, pending stays set for as long as the synchronized pin is low, even after an acknowledge.
- R5: Writing 1 to bit 2 of the register gives the same clear as a vector fetch. A falling edge after that write sets pending again.
- R6: Reset clears pending, the mode bit (bit 0) and the mask bit (bit 1). After reset, a pin that is still low does not set pending.
- R7: Bit 3 of the register reads the pending flag whatever the mask holds. `irq_req` is high exactly when pending is 1 and the mask is 0.
- R8: While `brk_active` is 1 and `brk_clr_en` is 0, software acknowledges leave the latch unchanged. The vector-fetch strobe still acts.
- R9: While `brk_active` is 1 and `brk_clr_en` is 1, a software acknowledge clears the latch. The latch stays cleared after the break ends.
- R10: Bit 2 of the register always reads 0. If a falling edge and an acknowledge land in the same cycle, the latch ends up set.
- R11: `pin_level` shows the synchronized pin, and `vec_addr` is constant at 16'hFFFA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data: bit0 mode, bit1 mask, bit2 acknowledge |
| reg_rdata | output | 8 | Read data: bit0 mode, bit1 mask, bit2 zero, bit3 pending |
| vec_ack | input | 1 | Vector-fetch acknowledge strobe |
| brk_active | input | 1 | Debug break state is active |
| brk_clr_en | input | 1 | Allows software clears during break |
| irq_req | output | 1 | Masked interrupt request to the CPU |
| pin_level | output | 1 | Synchronized pin level |
| vec_addr | output | 16 | Interrupt vector address |

## Verification
A synchronized falling edge and an acknowledge can reach the latch in the same cycle. In that case setting must win over clearing. The bench provokes this in edge mode. It drops the pin and counts the synchronizer stages. It then issues the software acknowledge exactly in the cycle that the edge detector fires. It judges the result by reading the pending bit a few cycles later: if the clear had won, the bit would read 0 instead of 1.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int REG_W  = 8;
  localparam int B_MODE = 0;
  localparam int B_MASK = 1;
  localparam int B_ACK  = 2;
  localparam int B_PEND = 3;
  localparam int VEC_W  = 16;
  localparam logic [VEC_W-1:0] VEC_ADDR = 16'hFFFA;

  // Status word seen by software; the acknowledge position reads zero.
  function automatic logic [REG_W-1:0] pack_status(input logic mode, input logic mask,
                                                   input logic pend);
    logic [REG_W-1:0] w;
    w         = '0;
    w[B_MODE] = mode;
    w[B_MASK] = mask;
    w[B_PEND] = pend;
    return w;
  endfunction

  // Clear rule: edge mode clears on any acknowledge, level mode needs the
  // pin high plus an acknowledge now or one remembered from earlier.
  function automatic logic clear_rule(input logic level, input logic pin_hi,
                                      input logic ack, input logic seen);
    if (level) return pin_hi & (ack | seen);
    return ack;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_n;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_n};
    end
  endgenerate

  // Reset to 0 so a pin held low through reset yields no edge afterwards.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign lvl  = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             pend,
  output logic             mode_q,
  output logic             mask_q,
  output logic             ack_wr,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr) begin
      mode_q <= wdata[B_MODE];
      mask_q <= wdata[B_MASK];
    end

  assign ack_wr = wr & wdata[B_ACK];
  assign rdata  = pack_status(mode_q, mask_q, pend);
endmodule

// File: rtl/xirq_core.sv
module xirq_core
  import xirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic pin_hi,
  input  logic level_mode,
  input  logic ack,
  output logic latch_q,
  output logic seen_q
);
  logic clr_now;
  logic seen_set;

  assign clr_now  = latch_q & clear_rule(level_mode, pin_hi, ack, seen_q);
  assign seen_set = level_mode & latch_q & ack & ~pin_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       latch_q <= 1'b0;
    else if (fall)    latch_q <= 1'b1;
    else if (clr_now) latch_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   seen_q <= 1'b0;
    else if (fall)                seen_q <= 1'b0;
    else if (clr_now)             seen_q <= 1'b0;
    else if (seen_set)            seen_q <= 1'b1;
    else if (!level_mode)         seen_q <= 1'b0;
endmodule

// File: rtl/xirq_latch.sv
module xirq_latch
  import xirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             vec_ack,
  input  logic             brk_active,
  input  logic             brk_clr_en,
  output logic             irq_req,
  output logic             pin_level,
  output logic [VEC_W-1:0] vec_addr
);
  logic sync_lvl, fall_evt;
  logic mode_q, mask_q;
  logic ack_sw_raw, ack_sw_eff, ack_any;
  logic latch_q, seen_q;

  xirq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .lvl(sync_lvl), .fall(fall_evt)
  );

  xirq_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .pend(latch_q),
    .mode_q(mode_q), .mask_q(mask_q), .ack_wr(ack_sw_raw), .rdata(reg_rdata)
  );

  // Break protection applies to software acknowledges only.
  assign ack_sw_eff = ack_sw_raw & ~(brk_active & ~brk_clr_en);
  assign ack_any    = ack_sw_eff | vec_ack;

  xirq_core core_i (
    .clk(clk), .rst_n(rst_n), .fall(fall_evt), .pin_hi(sync_lvl),
    .level_mode(mode_q), .ack(ack_any), .latch_q(latch_q), .seen_q(seen_q)
  );

  assign irq_req   = latch_q & ~mask_q;
  assign pin_level = sync_lvl;
  assign vec_addr  = VEC_ADDR;
endmodule

// File: rtl/xirq_latch_chk.sv
module xirq_latch_chk
  import xirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fall_evt,
  input logic             sync_lvl,
  input logic             mode_q,
  input logic             mask_q,
  input logic             latch_q,
  input logic             ack_any,
  input logic             ack_sw_raw,
  input logic             vec_ack,
  input logic             brk_active,
  input logic             brk_clr_en,
  input logic             irq_req,
  input logic [REG_W-1:0] reg_rdata
);
  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> latch_q);

  assert_edge_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && ack_any && !fall_evt) |=> !latch_q);

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && latch_q && !sync_lvl) |=> latch_q);

  assert_brk_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && brk_active && !brk_clr_en && ack_sw_raw && !vec_ack && latch_q)
      |=> latch_q);

  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq_req);

  assert_unmasked_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !mask_q) |-> irq_req);

  assert_ack_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[B_ACK] == 1'b0);
endmodule

bind xirq_latch xirq_latch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .sync_lvl(sync_lvl),
  .mode_q(mode_q), .mask_q(mask_q), .latch_q(latch_q), .ack_any(ack_any),
  .ack_sw_raw(ack_sw_raw), .vec_ack(vec_ack), .brk_active(brk_active),
  .brk_clr_en(brk_clr_en), .irq_req(irq_req), .reg_rdata(reg_rdata)
);

// File: tb/xirq_latch_tb_top.sv
module xirq_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       vec_ack = 1'b0;
  logic       brk_active = 1'b0;
  logic       brk_clr_en = 1'b0;
  logic       irq_req;
  logic       pin_level;
  logic [15:0] vec_addr;
  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  xirq_latch dut_i (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_ack(vec_ack),
    .brk_active(brk_active), .brk_clr_en(brk_clr_en), .irq_req(irq_req),
    .pin_level(pin_level), .vec_addr(vec_addr)
  );

  // Row: pin, wr, wdata[3:0], vack, brk, bce, expected rdata[3:0], expected irq, req
  // Register layout: bit0 mode, bit1 mask, bit2 ack (reads 0), bit3 pending.
  localparam logic [17:0] TBL [22] = '{
    {1'b1,1'b1,4'h0,1'b0,1'b0,1'b0,4'h0,1'b0,4'd6}, // R6 edge mode, unmasked
    {1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h8,1'b1,4'd1}, // R1 edge sets
    {1'b1,1'b0,4'h0,1'b1,1'b0,1'b0,4'h0,1'b0,4'd2}, // R2 vector fetch clears
    {1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h8,1'b1,4'd1}, // R1
    {1'b1,1'b1,4'h4,1'b0,1'b0,1'b0,4'h0,1'b0,4'd5}, // R5 software ack clears
    {1'b0,1'b1,4'h2,1'b0,1'b0,1'b0,4'hA,1'b0,4'd7}, // R7 R5 new edge, masked
    {1'b1,1'b1,4'h0,1'b0,1'b0,1'b0,4'h8,1'b1,4'd7}, // R7 unmask shows request
    {1'b1,1'b1,4'h4,1'b0,1'b0,1'b0,4'h0,1'b0,4'd5}, // R5
    {1'b1,1'b1,4'h1,1'b0,1'b0,1'b0,4'h1,1'b0,4'd6}, // R6 level mode on
    {1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h9,1'b1,4'd1}, // R1 level mode edge
    {1'b0,1'b1,4'h5,1'b0,1'b0,1'b0,4'h9,1'b1,4'd4}, // R4 ack while low holds
    {1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,4'h1,1'b0,4'd3}, // R3 pin high after ack
    {1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h9,1'b1,4'd1}, // R1
    {1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,4'h9,1'b1,4'd3}, // R3 pin high alone
    {1'b1,1'b1,4'h5,1'b0,1'b0,1'b0,4'h1,1'b0,4'd3}, // R3 ack after pin high
    {1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h9,1'b1,4'd1}, // R1
    {1'b1,1'b1,4'h5,1'b0,1'b1,1'b0,4'h9,1'b1,4'd8}, // R8 ack blocked in break
    {1'b1,1'b0,4'h0,1'b1,1'b1,1'b0,4'h1,1'b0,4'd8}, // R8 vector fetch still acts
    {1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h9,1'b1,4'd1}, // R1
    {1'b1,1'b0,4'h0,1'b0,1'b1,1'b0,4'h9,1'b1,4'd3}, // R3
    {1'b1,1'b1,4'h5,1'b0,1'b1,1'b1,4'h1,1'b0,4'd9}, // R9 clear allowed in break
    {1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,4'h1,1'b0,4'd9}  // R9 stays cleared after break
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL R0: watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle(2);
    check(6, {reg_rdata, 7'b0, irq_req}, 16'h0000); // R6 state during reset
    rst_n = 1'b1;
    idle(4);
    check(6, {reg_rdata, 7'b0, irq_req}, 16'h0000); // R6 state after reset

    for (int i = 0; i < 22; i++) begin
      pin_n      = TBL[i][17];
      reg_wr     = TBL[i][16];
      reg_wdata  = {4'h0, TBL[i][15:12]};
      vec_ack    = TBL[i][11];
      brk_active = TBL[i][10];
      brk_clr_en = TBL[i][9];
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; vec_ack = 1'b0;
      idle(4);
      check(int'(TBL[i][3:0]), {reg_rdata, 7'b0, irq_req},
            {4'h0, TBL[i][8:5], 7'b0, TBL[i][4]});
    end
    brk_active = 1'b0; brk_clr_en = 1'b0;

    // R10: edge and software ack in the same cycle, edge mode; set must win.
    wr_reg(8'h00);
    idle(3);
    pin_n = 1'b0;
    @(negedge clk);            // first sync flop now low
    @(negedge clk);            // second flop low, edge detector firing
    reg_wr = 1'b1; reg_wdata = 8'h04;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    idle(2);
    check(10, {8'h0, reg_rdata}, 16'h0008); // R10 set wins, ack bit reads 0

    // R11: synchronized level and vector address.
    check(11, {15'h0, pin_level}, 16'h0000);
    pin_n = 1'b1;
    idle(3);
    check(11, {15'h0, pin_level}, 16'h0001);
    check(11, vec_addr, 16'hFFFA);
    wr_reg(8'h04);
    idle(1);
    check(2, {8'h0, reg_rdata}, 16'h0000); // R2 software ack in edge mode

    // R6: reset with level mode, pending and the pin held low.
    wr_reg(8'h01);
    pin_n = 1'b0;
    idle(4);
    check(1, {8'h0, reg_rdata}, 16'h0009);
    rst_n = 1'b0;
    idle(2);
    check(6, {reg_rdata, 7'b0, irq_req}, 16'h0000);
    rst_n = 1'b1;
    idle(6);
    check(6, {reg_rdata, 7'b0, irq_req}, 16'h0000); // R6 low pin does not re-set

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule